// File: doc/BRIEF.md
# Associative Tag Store

This block is the tag store of a fully associative cache. It holds up to 256 tags of 20 bits, each with a valid bit. A lookup presents one key. The key is sent to every entry at once, every entry compares it with its own tag in the same cycle, and the block returns a hit flag and the binary position of the entry that matched. No entry is scanned in sequence, so a lookup costs the same single cycle at any depth.

Software or a cache controller loads tags through a write port that names an entry, a key and the valid bit to store with it. A flush input clears every valid bit in one cycle. The block assumes that no two valid entries hold the same key. It leaves victim selection and the line payload to the logic around it.

The result is registered. Hit and index appear on the clock edge after the lookup strobe. A write or flush in the strobe cycle takes effect only after the lookup has sampled the stored contents.

Top module: `cam_tag_store`

## Requirements
- R1: After reset, every valid bit is clear, `hit` is 0 and `hit_idx` is 0, so any lookup misses until an entry is written.
- R2: A write with `wr_en`=1 stores `wr_key` and `wr_valid` into entry `wr_idx`. A later lookup of that key with `wr_valid`=1 returns `hit`=1 and `hit_idx` equal to that entry number, for entries 0 through 255.
- R3: An entry whose stored valid bit is 0 never matches, even when its stored key equals the search key.
- R4: `hit` and `hit_idx` describe the lookup strobed with `srch_en`=1 on the previous clock edge. When `srch_en` was 0 at that edge, `hit` is 0 and `hit_idx` is 0.
- R5: Whenever `hit` is 0, `hit_idx` is 0.
- R6: A lookup in the same cycle as a write or flush sees the contents from before that write or flush.
- R7: `flush`=1 clears every valid bit at the next edge. When `flush` and `wr_en` are both 1 in one cycle, the flush wins and the write is dropped.
- R8: All 20 key bits take part in the compare. A key that differs from a stored tag in any single bit does not match it.
- R9: Writing an entry again replaces its old tag. The old key then misses and the new key hits at that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | 8 | Entry to load |
| wr_key | input | 20 | Tag to store |
| wr_valid | input | 1 | Valid bit to store with the tag |
| flush | input | 1 | Clear all valid bits |
| srch_en | input | 1 | Lookup strobe |
| srch_key | input | 20 | Key to look up |
| hit | output | 1 | Registered: some valid entry matched |
| hit_idx | output | 8 | Registered: position of the matching entry, 0 on miss |

## Verification
The hardest cases to reach from the ports are the edge collisions. One is a lookup in the same cycle as a write that changes the looked-up entry. Another is a flush that arrives together with a write. The bench drives both on purpose: it looks up the old and the new key during an overwrite, and it checks a key written in the flush cycle afterwards. The other hard case is the compare width. Single-bit neighbours of a stored tag are searched for all 20 bit positions. Then the whole array is filled with distinct tags and every one is looked up, so both ends of the index range and each index bit are covered.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic {
      ENC_OR_TREE = 1'b0,
      ENC_PRIORITY = 1'b1
   } enc_style_e;
endpackage

// File: rtl/cam_entry_array.sv
module cam_entry_array #(
   parameter int ENTRIES = 256,
   parameter int KEY_W = 20,
   parameter int IDX_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [KEY_W-1:0]   wr_key,
   input  logic               wr_valid,
   input  logic               flush,
   input  logic [KEY_W-1:0]   srch_key,
   output logic [ENTRIES-1:0] match
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [KEY_W-1:0] tag_q;
      logic             vld_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
         end else if (flush) begin
            vld_q <= 1'b0;
         end else if (sel) begin
            vld_q <= wr_valid;
         end
      end

      always_ff @(posedge clk) begin
         if (sel && !flush) begin
            tag_q <= wr_key;
         end
      end

      assign match[e] = vld_q && (tag_q == srch_key);
   end
endmodule

// File: rtl/cam_match_encoder.sv
module cam_match_encoder
   import cam_pkg::*;
#(
   parameter int ENTRIES = 256,
   parameter int IDX_W = 8,
   parameter enc_style_e ENC = ENC_OR_TREE
) (
   input  logic [ENTRIES-1:0] match,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   assign any = |match;

   if (ENC == ENC_OR_TREE) begin : g_or
      for (genvar b = 0; b < IDX_W; b++) begin : g_bit
         logic [ENTRIES-1:0] mask;
         for (genvar e = 0; e < ENTRIES; e++) begin : g_m
            assign mask[e] = ((e >> b) & 1) == 1;
         end
         assign idx[b] = |(match & mask);
      end
   end else begin : g_prio
      always_comb begin
         idx = '0;
         for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) idx = IDX_W'(e);
         end
      end
   end
endmodule

// File: rtl/cam_result_reg.sv
module cam_result_reg #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srch_en,
   input  logic             any,
   input  logic [IDX_W-1:0] idx,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         hit_idx <= '0;
      end else begin
         hit     <= srch_en && any;
         hit_idx <= (srch_en && any) ? idx : '0;
      end
   end
endmodule

// File: rtl/cam_tag_store.sv
module cam_tag_store
   import cam_pkg::*;
#(
   parameter int ENTRIES = 256,
   parameter int KEY_W = 20,
   parameter enc_style_e ENC = ENC_OR_TREE,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [KEY_W-1:0] wr_key,
   input  logic             wr_valid,
   input  logic             flush,
   input  logic             srch_en,
   input  logic [KEY_W-1:0] srch_key,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx
);
   if (ENTRIES < 2 || ENTRIES != (1 << IDX_W)) begin : g_bad_depth
      $error("cam_tag_store: ENTRIES must be a power of two of at least 2");
   end
   if (KEY_W < 1) begin : g_bad_key
      $error("cam_tag_store: KEY_W must be positive");
   end

   logic [ENTRIES-1:0] match;
   logic               any;
   logic [IDX_W-1:0]   idx;

   cam_entry_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
      .wr_valid(wr_valid), .flush(flush), .srch_key(srch_key), .match(match)
   );

   cam_match_encoder #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .ENC(ENC)) u_enc (
      .match(match), .any(any), .idx(idx)
   );

   cam_result_reg #(.IDX_W(IDX_W)) u_res (
      .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .any(any), .idx(idx),
      .hit(hit), .hit_idx(hit_idx)
   );
endmodule

// File: rtl/cam_tag_store_chk.sv
module cam_tag_store_chk #(
   parameter int KEY_W = 20,
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [KEY_W-1:0] wr_key,
   input logic             wr_valid,
   input logic             flush,
   input logic             srch_en,
   input logic [KEY_W-1:0] srch_key,
   input logic             hit,
   input logic [IDX_W-1:0] hit_idx
);
   AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> hit_idx == '0); // R5

   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_en |=> (!hit && hit_idx == '0)); // R4

   AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_valid && !flush) ##1
      (srch_en && !wr_en && !flush && srch_key == $past(wr_key))
      |=> (hit && hit_idx == $past(wr_idx, 2))); // R2

   AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_valid && !flush) ##1
      (srch_en && !wr_en && !flush && srch_key == $past(wr_key))
      |=> !hit); // R3

   AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      flush ##1 (srch_en && !wr_en && !flush) |=> !hit); // R7
endmodule

bind cam_tag_store cam_tag_store_chk #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
   .wr_valid(wr_valid), .flush(flush), .srch_en(srch_en), .srch_key(srch_key),
   .hit(hit), .hit_idx(hit_idx)
);

// File: tb/tb_cam_tag_store.sv
module tb_cam_tag_store;
   localparam int N = 256;
   localparam int KW = 20;
   localparam int IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [KW-1:0] wr_key = '0;
   logic          wr_valid = 1'b0;
   logic          flush = 1'b0;
   logic          srch_en = 1'b0;
   logic [KW-1:0] srch_key = '0;
   logic          hit;
   logic [IW-1:0] hit_idx;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [KW-1:0] m_key [N];
   bit            m_vld [N];

   always #10 clk = ~clk;

   cam_tag_store dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_key(wr_key),
      .wr_valid(wr_valid), .flush(flush), .srch_en(srch_en), .srch_key(srch_key),
      .hit(hit), .hit_idx(hit_idx)
   );

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   task automatic compare(input string req, input bit eh, input int ei);
      checks++;
      if (hit !== eh || hit_idx !== IW'(ei)) begin
         fails++;
         $display("FAIL %s: hit=%0b idx=%0d expected hit=%0b idx=%0d", req, hit, hit_idx, eh, ei);
      end
   endtask

   // One clock: drive at the falling edge, predict from the model as it was
   // before the edge, update the model, then compare at the next falling edge.
   task automatic cyc(input string req, input bit we, input int wi, input int wk,
                      input bit wv, input bit fl, input bit se, input int sk);
      bit eh = 1'b0;
      int ei = 0;
      wr_en = we; wr_idx = IW'(wi); wr_key = KW'(wk); wr_valid = wv;
      flush = fl; srch_en = se; srch_key = KW'(sk);
      if (se) begin
         for (int e = 0; e < N; e++) begin
            if (m_vld[e] && m_key[e] == KW'(sk)) begin
               eh = 1'b1; ei = e;
            end
         end
      end
      if (fl) begin
         for (int e = 0; e < N; e++) m_vld[e] = 1'b0;
      end else if (we) begin
         m_key[wi] = KW'(wk); m_vld[wi] = wv;
      end
      @(posedge clk);
      @(negedge clk);
      compare(req, eh, ei);
   endtask

   task automatic wr(input string req, input int wi, input int wk, input bit wv);
      cyc(req, 1'b1, wi, wk, wv, 1'b0, 1'b0, 0);
   endtask

   task automatic look(input string req, input int sk);
      cyc(req, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1, sk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         report();
         $finish;
      end
   end

   initial begin
      for (int e = 0; e < N; e++) begin m_vld[e] = 1'b0; m_key[e] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1 outputs in reset", 1'b0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 outputs after reset", 1'b0, 0);
      look("R1 empty store miss key 0", 0);
      look("R1 empty store miss", 'hAB712);

      wr("R2 write entry 0x12", 'h12, 'hAB712, 1'b1);
      look("R2 hit entry 0x12", 'hAB712);
      wr("R2 write entry 0", 0, 'h00001, 1'b1);
      wr("R2 write entry 255", 255, 'hFFFFF, 1'b1);
      look("R2 hit entry 0", 'h00001);
      look("R2 hit entry 255", 'hFFFFF);
      look("R5 miss index zero", 'h12345);

      for (int b = 0; b < KW; b++) begin
         look("R8 single-bit neighbour miss", 'hAB712 ^ (1 << b));
      end

      wr("R3 write invalid entry", 5, 'h0CD41, 1'b0);
      look("R3 invalid entry no match", 'h0CD41);

      cyc("R4 no strobe no hit", 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 'hAB712);
      look("R4 strobe hit", 'hAB712);
      cyc("R4 idle after hit", 1'b0, 0, 0, 1'b0, 1'b0, 1'b0, 0);

      wr("R9 load entry 7", 7, 'h11111, 1'b1);
      cyc("R6 lookup new key during overwrite", 1'b1, 7, 'h22222, 1'b1, 1'b0, 1'b1, 'h22222);
      look("R9 new key hits", 'h22222);
      look("R9 old key misses", 'h11111);
      cyc("R6 lookup old key during overwrite", 1'b1, 7, 'h33333, 1'b1, 1'b0, 1'b1, 'h22222);
      look("R9 second overwrite hits", 'h33333);

      cyc("R6 lookup during flush", 1'b0, 0, 0, 1'b0, 1'b1, 1'b1, 'hAB712);
      look("R7 flushed entry misses", 'hAB712);
      look("R7 flushed entry 255 misses", 'hFFFFF);
      wr("R7 reload entry 9", 9, 'h5A5A5, 1'b1);
      cyc("R7 flush with write", 1'b1, 3, 'h77777, 1'b1, 1'b1, 1'b0, 0);
      look("R7 write dropped under flush", 'h77777);
      look("R7 earlier entry cleared", 'h5A5A5);

      for (int e = 0; e < N; e++) begin
         wr("R2 fill", e, 'h40000 + e * 37, 1'b1);
      end
      for (int e = 0; e < N; e++) begin
         look("R2 full sweep", 'h40000 + e * 37);
      end
      for (int e = 0; e < N; e += 17) begin
         wr("R3 clear valid", e, 'h40000 + e * 37, 1'b0);
         look("R3 cleared entry misses", 'h40000 + e * 37);
      end
      look("R5 miss after fill", 'hABCDE);

      done = 1'b1;
      report();
      $finish;
   end
endmodule